// File: doc/BRIEF.md
# Clock Generator Staged-Configuration Commit Controller

This block holds the programming of one root clock generator: which source feeds it, a pre-divider value, an operating mode, a hardware-control flag, and the three M, N and D values of its fractional divider. Software reaches it through a word-wide register port. Every configuration write lands in a staging copy, and the divider datapath keeps running from a separate active copy. The datapath therefore never sees a half-written setting while software updates several registers in turn.

To apply the staged settings, software writes 1 to the update bit of the command word and then polls that bit. The bit reads 1 for a fixed, parameterised number of cycles. In the cycle it drops, the active copy takes the staged values in a single step. The command word also carries a root-off status bit. It reads 1 from reset until the first commit has brought the generator to life. Source switching is modelled only as the active select value changing at the commit.

Top module: `clkgen_commit_ctrl`

## Requirements
- R1: After reset, every active output is 0, root_off is 1, and reads of all five registers return 0 except the command word, which returns 0x80000000.
- R2: Word addresses: command 0, configuration 1, M 2, N 3, D 4. The configuration word holds the pre-divider in bits [4:0], the source select in [10:8], the mode in [13:12] and the hardware-control flag in bit 20. A read of the configuration word returns the staged fields, and all other bits read 0.
- R3: M, N and D each keep the low 16 bits of the written word, and read back those bits zero-extended. A read-modify-write that changes one configuration field leaves the other fields as they were.
- R4: Writes to the staged registers do not change the active outputs until a commit loads them.
- R5: Writing a word with bit 0 set to the command register while idle makes bit 0 of the command word read 1 for exactly COMMIT_CYC cycles, default 4. On the clock edge where it clears, all active outputs take the staged values.
- R6: A command write with bit 0 clear starts no commit and changes nothing.
- R7: A command write with bit 0 set while a commit is pending, including in its final cycle, is ignored and neither restarts nor extends the commit.
- R8: Bit 31 of the command word and the root_off output stay 1 until the first commit completes, and 0 from then on.
- R9: A staged write accepted before the final pending cycle is carried by that commit. A staged write in the final pending cycle stays staged and does not reach the active outputs.
- R10: Writes to addresses 5 to 7 are ignored, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| act_src | output | 3 | Active source select |
| act_pdiv | output | 5 | Active pre-divider value |
| act_mode | output | 2 | Active divider mode |
| act_hwc | output | 1 | Active hardware-control flag |
| act_m | output | 16 | Active M value |
| act_n | output | 16 | Active N value |
| act_d | output | 16 | Active D value |
| root_off | output | 1 | 1 while the generated clock has not yet been started by a commit |

## Verification
The sharp case is the final pending cycle. There, the commit load and a software access can share one edge: a staged write, or a second update request. The bench places a write to M one cycle before the load and a write to N on the load edge itself. It expects the active M to take the new value and the active N to keep the old one, while the staged N reads back new. It repeats an update request inside the pending window and counts the polled cycles of the update bit. Randomised traffic then mixes command writes with staged writes, so that loads regularly coincide with writes, and every cycle is compared against a cycle-level model of the requirements.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
    // Register port geometry
    localparam int DW       = 32;
    localparam int AW       = 3;

    // Word addresses; M, N and D follow the configuration word in order
    localparam int OFS_CMD  = 0;
    localparam int OFS_CFG  = 1;
    localparam int OFS_M    = 2;
    localparam int MND_CNT  = 3;

    // Command word bits
    localparam int UPD_BIT  = 0;
    localparam int ROFF_BIT = 31;

    // Configuration word layout
    localparam int PDIV_W   = 5;
    localparam int PDIV_SH  = 0;
    localparam int SRC_W    = 3;
    localparam int SRC_SH   = 8;
    localparam int MODE_W   = 2;
    localparam int MODE_SH  = 12;
    localparam int HWC_SH   = 20;

    // Fractional divider value width
    localparam int MND_W    = 16;

    typedef struct packed {
        logic [SRC_W-1:0]                src;
        logic [PDIV_W-1:0]               pdiv;
        logic [MODE_W-1:0]               mode;
        logic                            hwc;
        logic [MND_CNT-1:0][MND_W-1:0]   mnd;   // 0 = M, 1 = N, 2 = D
    } clk_cfg_t;
endpackage

// File: rtl/clkgen_shadow_regs.sv
`timescale 1ns/1ps
module clkgen_shadow_regs
    import clkgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            pend,
    input  logic            root_off,
    output clk_cfg_t        shd,
    output logic [DW-1:0]   rdata
);
    clk_cfg_t             shd_d, shd_q;
    logic                 cfg_we;
    logic [MND_CNT-1:0]   mnd_we;
    logic                 unused_wbits;

    assign cfg_we       = wr_en && (addr == AW'(OFS_CFG));
    assign unused_wbits = ^wdata;

    for (genvar gi = 0; gi < MND_CNT; gi++) begin : g_mnd_we
        assign mnd_we[gi] = wr_en && (addr == AW'(OFS_M + gi));
    end

    always_comb begin
        shd_d = shd_q;
        if (cfg_we) begin
            shd_d.pdiv = wdata[PDIV_SH +: PDIV_W];
            shd_d.src  = wdata[SRC_SH  +: SRC_W];
            shd_d.mode = wdata[MODE_SH +: MODE_W];
            shd_d.hwc  = wdata[HWC_SH];
        end
        for (int i = 0; i < MND_CNT; i++) begin
            if (mnd_we[i]) begin
                shd_d.mnd[i] = wdata[MND_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else begin
            shd_q <= shd_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_CMD)) begin
            rdata[UPD_BIT]  = pend;
            rdata[ROFF_BIT] = root_off;
        end else if (addr == AW'(OFS_CFG)) begin
            rdata[PDIV_SH +: PDIV_W] = shd_q.pdiv;
            rdata[SRC_SH  +: SRC_W]  = shd_q.src;
            rdata[MODE_SH +: MODE_W] = shd_q.mode;
            rdata[HWC_SH]            = shd_q.hwc;
        end else begin
            for (int i = 0; i < MND_CNT; i++) begin
                if (addr == AW'(OFS_M + i)) begin
                    rdata[MND_W-1:0] = shd_q.mnd[i];
                end
            end
        end
    end

    assign shd = shd_q;
endmodule

// File: rtl/clkgen_commit_seq.sv
`timescale 1ns/1ps
module clkgen_commit_seq
    import clkgen_pkg::*;
#(
    parameter int COMMIT_CYC = 4
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic            upd_req,
    output logic            pend,
    output logic            load
);
    localparam int CNT_W = $clog2(COMMIT_CYC + 1);

    typedef struct packed {
        logic              pend;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic start;

    assign start = wr_en && (addr == AW'(OFS_CMD)) && upd_req;
    assign load  = seq_q.pend && (seq_q.cnt == '0);

    always_comb begin
        seq_d = seq_q;
        if (seq_q.pend) begin
            if (seq_q.cnt == '0) begin
                seq_d.pend = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end else if (start) begin
            seq_d.pend = 1'b1;
            seq_d.cnt  = CNT_W'(COMMIT_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pend = seq_q.pend;
endmodule

// File: rtl/clkgen_active_regs.sv
`timescale 1ns/1ps
module clkgen_active_regs
    import clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  clk_cfg_t  shd,
    output clk_cfg_t  act,
    output logic      root_off
);
    typedef struct packed {
        clk_cfg_t  cfg;
        logic      roff;
    } act_t;

    act_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (load) begin
            act_d.cfg  = shd;
            act_d.roff = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q.cfg  <= '0;
            act_q.roff <= 1'b1;
        end else begin
            act_q <= act_d;
        end
    end

    assign act      = act_q.cfg;
    assign root_off = act_q.roff;
endmodule

// File: rtl/clkgen_commit_ctrl.sv
`timescale 1ns/1ps
module clkgen_commit_ctrl
    import clkgen_pkg::*;
#(
    parameter int COMMIT_CYC = 4
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic [SRC_W-1:0]    act_src,
    output logic [PDIV_W-1:0]   act_pdiv,
    output logic [MODE_W-1:0]   act_mode,
    output logic                act_hwc,
    output logic [MND_W-1:0]    act_m,
    output logic [MND_W-1:0]    act_n,
    output logic [MND_W-1:0]    act_d,
    output logic                root_off
);
    clk_cfg_t shd_w;
    clk_cfg_t act_w;
    logic     pend_w;
    logic     load_w;

    clkgen_shadow_regs shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pend     (pend_w),
        .root_off (root_off),
        .shd      (shd_w),
        .rdata    (reg_rdata)
    );

    clkgen_commit_seq #(.COMMIT_CYC(COMMIT_CYC)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .upd_req  (reg_wdata[UPD_BIT]),
        .pend     (pend_w),
        .load     (load_w)
    );

    clkgen_active_regs active_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .shd      (shd_w),
        .act      (act_w),
        .root_off (root_off)
    );

    assign act_src  = act_w.src;
    assign act_pdiv = act_w.pdiv;
    assign act_mode = act_w.mode;
    assign act_hwc  = act_w.hwc;
    assign act_m    = act_w.mnd[0];
    assign act_n    = act_w.mnd[1];
    assign act_d    = act_w.mnd[2];
endmodule

// File: rtl/clkgen_commit_ctrl_chk.sv
`timescale 1ns/1ps
module clkgen_commit_ctrl_chk
    import clkgen_pkg::*;
#(
    parameter int COMMIT_CYC = 4
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic            upd_req,
    input  logic            pend,
    input  logic            load,
    input  logic            root_off,
    input  clk_cfg_t        shd,
    input  clk_cfg_t        act
);
    int  win_q;
    logic start_req;

    assign start_req = reg_wr && (reg_addr == AW'(OFS_CMD)) && upd_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= 0;
        end else if (pend) begin
            win_q <= win_q + 1;
        end else begin
            win_q <= 0;
        end
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act)); // R4

    AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (act == $past(shd))); // R5

    AST_PEND_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (win_q == COMMIT_CYC - 1)); // R5

    AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !start_req) |=> !pend); // R6

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !pend); // R7

    AST_ROFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !root_off |=> !root_off); // R8

    AST_ROFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (root_off && !load) |=> root_off); // R8
endmodule

bind clkgen_commit_ctrl clkgen_commit_ctrl_chk #(.COMMIT_CYC(COMMIT_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .upd_req  (reg_wdata[clkgen_pkg::UPD_BIT]),
    .pend     (pend_w),
    .load     (load_w),
    .root_off (root_off),
    .shd      (shd_w),
    .act      (act_w)
);

// File: tb/clkgen_commit_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkgen_commit_ctrl_tb_top;
    localparam int CC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  act_src;
    logic [4:0]  act_pdiv;
    logic [1:0]  act_mode;
    logic        act_hwc;
    logic [15:0] act_m, act_n, act_d;
    logic        root_off;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state derived from the requirements
    logic [31:0] s_cfg;                 // staged configuration word as read back
    logic [15:0] s_mnd [3];
    logic [31:0] a_cfg;
    logic [15:0] a_mnd [3];
    bit          m_pend;
    int          m_left;
    bit          m_roff;

    always #10 clk = ~clk;   // 50 MHz

    clkgen_commit_ctrl #(.COMMIT_CYC(CC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_src(act_src),
        .act_pdiv(act_pdiv), .act_mode(act_mode), .act_hwc(act_hwc),
        .act_m(act_m), .act_n(act_n), .act_d(act_d), .root_off(root_off)
    );

    localparam logic [31:0] CFG_MASK = 32'h0010_371F;

    function automatic logic [31:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: exp_read = {m_roff, 30'd0, m_pend};
            3'd1: exp_read = s_cfg;
            3'd2: exp_read = {16'd0, s_mnd[0]};
            3'd3: exp_read = {16'd0, s_mnd[1]};
            3'd4: exp_read = {16'd0, s_mnd[2]};
            default: exp_read = 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(bit w, logic [2:0] a, logic [31:0] d);
        if (m_pend) begin
            if (m_left == 0) begin
                a_cfg = s_cfg;
                for (int i = 0; i < 3; i++) a_mnd[i] = s_mnd[i];
                m_pend = 0;
                m_roff = 0;
            end else begin
                m_left--;
            end
        end else if (w && a == 3'd0 && d[0]) begin
            m_pend = 1;
            m_left = CC - 1;
        end
        if (w) begin
            if (a == 3'd1) s_cfg = d & CFG_MASK;
            else if (a >= 3'd2 && a <= 3'd4) s_mnd[a-2] = d[15:0];
        end
    endtask

    task automatic check_outputs(string tag);
        chk({tag, " act_src"},  {29'd0, act_src},  {29'd0, a_cfg[10:8]});
        chk({tag, " act_pdiv"}, {27'd0, act_pdiv}, {27'd0, a_cfg[4:0]});
        chk({tag, " act_mode"}, {30'd0, act_mode}, {30'd0, a_cfg[13:12]});
        chk({tag, " act_hwc"},  {31'd0, act_hwc},  {31'd0, a_cfg[20]});
        chk({tag, " act_m"},    {16'd0, act_m},    {16'd0, a_mnd[0]});
        chk({tag, " act_n"},    {16'd0, act_n},    {16'd0, a_mnd[1]});
        chk({tag, " act_d"},    {16'd0, act_d},    {16'd0, a_mnd[2]});
        chk({tag, " root_off"}, {31'd0, root_off}, {31'd0, m_roff});
    endtask

    // One cycle: drive after the falling edge, check read, clock, check outputs
    task automatic cyc(bit w, logic [2:0] a, logic [31:0] d, string tag);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        chk({tag, " rdata"}, reg_rdata, exp_read(a));
        @(posedge clk);
        model_step(w, a, d);
        @(negedge clk);
        reg_wr = 1'b0;
        check_outputs(tag);
    endtask

    task automatic read_now(logic [2:0] a, output logic [31:0] v);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cnt;
        logic [15:0] old_n;
        void'($urandom(32'd7531));
        s_cfg = 0; a_cfg = 0; m_pend = 0; m_left = 0; m_roff = 1;
        for (int i = 0; i < 3; i++) begin s_mnd[i] = 0; a_mnd[i] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_outputs("R1");
        read_now(3'd0, v); chk("R1 cmd reset", v, 32'h8000_0000);
        for (int a = 1; a <= 4; a++) begin
            read_now(3'(a), v); chk("R1 reg reset", v, 32'd0);
        end

        // R2: configuration write lands in staging, other bits read 0
        cyc(1, 3'd1, 32'hFFFF_FFFF, "R2");
        read_now(3'd1, v); chk("R2 cfg readback", v, 32'h0010_371F);
        check_outputs("R4 after cfg write");

        // R3: read-modify-write of the pre-divider only
        read_now(3'd1, v);
        cyc(1, 3'd1, (v & ~32'h1F) | 32'h05, "R3");
        read_now(3'd1, v); chk("R3 rmw keeps fields", v, 32'h0010_3705);

        // R3: M, N, D keep low 16 bits
        cyc(1, 3'd2, 32'hABCD_1234, "R3");
        cyc(1, 3'd3, 32'h5555_0042, "R3");
        cyc(1, 3'd4, 32'hFFFF_00FF, "R3");
        read_now(3'd2, v); chk("R3 m readback", v, 32'h0000_1234);
        read_now(3'd4, v); chk("R3 d readback", v, 32'h0000_00FF);
        chk("R4 act_m before commit", {16'd0, act_m}, 32'd0);

        // R6: update bit written as 0
        cyc(1, 3'd0, 32'hFFFF_FFFE, "R6");
        read_now(3'd0, v); chk("R6 no commit", v, 32'h8000_0000);
        chk("R6 root_off", {31'd0, root_off}, 32'd1);

        // R5/R8: commit window length and load
        cyc(1, 3'd0, 32'h1, "R5");
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            read_now(3'd0, v);
            if (v[0]) cnt++;
            if (cnt == CC && v[0]) chk("R4 act before load", {27'd0, act_pdiv}, 32'd0);
            cyc(0, 3'd0, 32'h0, "R5 poll");
        end
        chk("R5 pending cycles", cnt, CC);
        chk("R5 act_pdiv loaded", {27'd0, act_pdiv}, 32'd5);
        chk("R5 act_m loaded", {16'd0, act_m}, 32'h1234);
        chk("R8 root_off cleared", {31'd0, root_off}, 32'd0);

        // R7: second update request inside pending window
        cyc(1, 3'd0, 32'h1, "R7");
        cyc(1, 3'd0, 32'h1, "R7");
        cnt = 1;
        for (int k = 0; k < 10; k++) begin
            read_now(3'd0, v);
            if (v[0]) cnt++;
            cyc((k == 1), 3'd0, 32'h1, "R7 poll");
        end
        chk("R7 window not extended", cnt, CC);

        // R9: write one cycle before load is carried, write on load edge is not
        old_n = act_n;
        cyc(1, 3'd0, 32'h1, "R9");          // edge E0
        cyc(0, 3'd0, 32'h0, "R9");          // E1
        cyc(0, 3'd0, 32'h0, "R9");          // E2
        cyc(1, 3'd2, 32'h0000_BEEF, "R9");  // E3
        cyc(1, 3'd3, 32'h0000_CAFE, "R9");  // E4, load edge
        chk("R9 m carried", {16'd0, act_m}, 32'h0000_BEEF);
        chk("R9 n not carried", {16'd0, act_n}, {16'd0, old_n});
        read_now(3'd3, v); chk("R9 n staged", v, 32'h0000_CAFE);

        // R10: unmapped addresses
        for (int a = 5; a <= 7; a++) begin
            cyc(1, 3'(a), 32'hFFFF_FFFF, "R10");
            read_now(3'(a), v); chk("R10 unmapped read", v, 32'd0);
        end

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            int r;
            logic [2:0] a;
            logic [31:0] d;
            r = $urandom_range(0, 99);
            d = $urandom();
            if (r < 25) cyc(1, 3'd0, d, "R5 rand cmd");
            else if (r < 65) begin
                a = 3'($urandom_range(1, 7));
                cyc(1, a, d, "R9 rand write");
            end else begin
                a = 3'($urandom_range(0, 7));
                cyc(0, a, d, "R4 rand idle");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule